// File: doc/BRIEF.md
# Expander Bus Host Sequencer

This block is the host-side engine for a latch expander that is reached over an 8-bit data bus and a small set of active-low control lines. A single request names one of three operations: load the expander's address register, write a byte into the latch that is currently addressed, or read a byte back from an addressed input latch. The block then steps the data bus, a 4-bit control code and a bus-direction flag through the fixed order that the expander needs. It waits for completion and reports it.

The control codes model the inversion of the physical lines. Code 4 leaves both the address-load line and the data strobe inactive. Code 12 pulls the address-load line low. Code 5 pulls the data strobe low. During a read, the direction flag is raised together with code 5. This stops the host driving the bus while the addressed input latch drives it. Every step is held for a programmable number of clock cycles so that slow expander logic has time to settle. A nonzero runtime value overrides the compile-time default.

Top module: `xbus_host_seq`

## Requirements
- R1: After a synchronous reset the outputs are as follows: `ctrl` is 4, `dir_in` is 0, `busy` is 0, `done` is 0, `bus_out` is 0 and `rd_data` is 0.
- R2: `ctrl` only ever takes the values 4 (idle), 12 (address-load low) and 5 (strobe low). `dir_in` is 1 only while `ctrl` is 5 during a read.
- R3: An address write (`req_op`=0) sets `bus_out` to bank*16+port, with bit 7 = 0, bits 6:4 = bank and bits 3:0 = port. It then holds `ctrl`=4 for N cycles, then `ctrl`=12 for N cycles, and then returns to 4. `bus_out` does not change while `ctrl` is 12.
- R4: A data write (`req_op`=1) sets `bus_out` to `req_data`. It then holds `ctrl`=4 for N cycles, then `ctrl`=5 with `dir_in`=0 for N cycles, and then returns to 4.
- R5: A read (`req_op`=2) has no setup step. From the cycle after acceptance, `ctrl`=5 and `dir_in`=1 are held for N cycles, and `bus_out` keeps its previous value.
- R6: At the end of a read, `rd_data` holds the `bus_in` value present in the last cycle of the strobe step. Earlier values are discarded. Write operations leave `rd_data` unchanged.
- R7: N equals `hold_cfg` when `hold_cfg` is nonzero, and HOLD_DEF otherwise. N is sampled when the request is accepted, so later changes to `hold_cfg` do not affect an operation already running.
- R8: A request is accepted when `req_valid` is high while `busy` is low. `busy` goes high in the next cycle and stays high until completion. Requests made while `busy` is high are ignored.
- R9: `done` is a single-cycle pulse. It appears in the same cycle that `busy` falls and `ctrl` returns to 4.
- R10: The reserved operation code 3 is ignored. It causes no `busy`, no `done` and no change on `bus_out` or `ctrl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 2 | 0 address write, 1 data write, 2 read, 3 reserved |
| req_bank | input | 3 | Bank number for an address write |
| req_port | input | 4 | Port number within the bank |
| req_data | input | 8 | Byte for a data write |
| hold_cfg | input | 8 | Runtime step hold in cycles; 0 selects HOLD_DEF |
| bus_in | input | 8 | Byte driven by the expander during a read |
| bus_out | output | 8 | Byte the host drives onto the data bus |
| ctrl | output | 4 | Encoded control lines (4 idle, 12 address load, 5 strobe) |
| dir_in | output | 1 | 1 while the host output driver is released for a read |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |

## Verification
The bench traces every cycle of each operation for hold values of 1, 3 and 5. A counter that is off by one would stretch or cut a step, and skipping the setup step would pulse a latch before its data is valid. The bench changes `bus_in` during the strobe step of a read. A design that samples too early, or one cycle late after the bus is released, would return the stale byte. Requests made while busy, a `hold_cfg` change during an operation and the reserved opcode are all issued. A design that re-arms, re-samples the hold or treats code 3 as a read would show it on `busy`, `ctrl` or `bus_out`.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;

  typedef enum logic [1:0] {
    OP_ADDR = 2'd0,
    OP_DATA = 2'd1,
    OP_READ = 2'd2,
    OP_RSVD = 2'd3
  } xop_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2
  } phase_e;

  // Encoded control lines: inversion of the physical pins is folded in here.
  localparam logic [3:0] CTL_REST = 4'd4;
  localparam logic [3:0] CTL_SEL  = 4'd12;
  localparam logic [3:0] CTL_STB  = 4'd5;

endpackage

// File: rtl/xbus_hold_timer.sv
module xbus_hold_timer #(
  parameter int HOLD_W   = 8,
  parameter int HOLD_DEF = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HOLD_W-1:0] hold_cfg,
  input  logic              arm,
  input  logic              rearm,
  output logic              last
);

  localparam logic [HOLD_W-1:0] DEF_V = HOLD_W'(HOLD_DEF);
  localparam logic [HOLD_W-1:0] ONE_V = HOLD_W'(1);

  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] cnt_q;
  logic [HOLD_W-1:0] eff;

  // A zero runtime value falls back to the compile-time default.
  assign eff = (hold_cfg != '0) ? hold_cfg : DEF_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= DEF_V;
      cnt_q  <= '0;
    end else if (arm) begin
      hold_q <= eff;
      cnt_q  <= eff - ONE_V;
    end else if (rearm) begin
      cnt_q  <= hold_q - ONE_V;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - ONE_V;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/xbus_step_fsm.sv
module xbus_step_fsm
  import xbus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_op,
  input  logic       last,
  output logic       start,
  output logic       to_pulse,
  output logic       finish,
  output logic       busy,
  output logic [1:0] op_q
);

  phase_e ph_q;

  assign start    = (ph_q == PH_IDLE) && req_valid && (req_op != OP_RSVD);
  assign to_pulse = (ph_q == PH_SETUP) && last;
  assign finish   = (ph_q == PH_PULSE) && last;
  assign busy     = (ph_q != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_IDLE;
      op_q <= OP_ADDR;
    end else if (start) begin
      op_q <= req_op;
      ph_q <= (req_op == OP_READ) ? PH_PULSE : PH_SETUP;
    end else if (to_pulse) begin
      ph_q <= PH_PULSE;
    end else if (finish) begin
      ph_q <= PH_IDLE;
    end
  end

endmodule

// File: rtl/xbus_drive_regs.sv
module xbus_drive_regs
  import xbus_seq_pkg::*;
#(
  parameter int DW     = 8,
  parameter int BANK_W = 3,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              to_pulse,
  input  logic              finish,
  input  logic [1:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [PORT_W-1:0] req_port,
  input  logic [DW-1:0]     req_data,
  input  logic [1:0]        op_q,
  input  logic [DW-1:0]     bus_in,
  output logic [DW-1:0]     bus_out,
  output logic [3:0]        ctrl,
  output logic              dir_in,
  output logic [DW-1:0]     rd_data,
  output logic              done
);

  localparam int ADDR_W = BANK_W + PORT_W;

  logic [DW-1:0] addr_byte;

  generate
    if (ADDR_W < DW) begin : g_pad
      assign addr_byte = {{(DW-ADDR_W){1'b0}}, req_bank, req_port};
    end else begin : g_trunc
      logic [ADDR_W-1:0] full_addr;
      assign full_addr = {req_bank, req_port};
      assign addr_byte = full_addr[DW-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out <= '0;
      ctrl    <= CTL_REST;
      dir_in  <= 1'b0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (req_op == OP_ADDR) begin
          bus_out <= addr_byte;
        end else if (req_op == OP_DATA) begin
          bus_out <= req_data;
        end else begin
          ctrl   <= CTL_STB;
          dir_in <= 1'b1;
        end
      end else if (to_pulse) begin
        ctrl <= (op_q == OP_ADDR) ? CTL_SEL : CTL_STB;
      end else if (finish) begin
        ctrl   <= CTL_REST;
        dir_in <= 1'b0;
        done   <= 1'b1;
        if (op_q == OP_READ) begin
          rd_data <= bus_in;
        end
      end
    end
  end

endmodule

// File: rtl/xbus_host_seq.sv
module xbus_host_seq #(
  parameter int DW       = 8,
  parameter int BANK_W   = 3,
  parameter int PORT_W   = 4,
  parameter int HOLD_W   = 8,
  parameter int HOLD_DEF = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [PORT_W-1:0] req_port,
  input  logic [DW-1:0]     req_data,
  input  logic [HOLD_W-1:0] hold_cfg,
  input  logic [DW-1:0]     bus_in,
  output logic [DW-1:0]     bus_out,
  output logic [3:0]        ctrl,
  output logic              dir_in,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rd_data
);

  logic       start;
  logic       to_pulse;
  logic       finish;
  logic       last;
  logic [1:0] op_q;

  xbus_step_fsm fsm_i (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_op   (req_op),
    .last     (last),
    .start    (start),
    .to_pulse (to_pulse),
    .finish   (finish),
    .busy     (busy),
    .op_q     (op_q)
  );

  xbus_hold_timer #(
    .HOLD_W  (HOLD_W),
    .HOLD_DEF(HOLD_DEF)
  ) timer_i (
    .clk     (clk),
    .rst     (rst),
    .hold_cfg(hold_cfg),
    .arm     (start),
    .rearm   (to_pulse),
    .last    (last)
  );

  xbus_drive_regs #(
    .DW    (DW),
    .BANK_W(BANK_W),
    .PORT_W(PORT_W)
  ) regs_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .to_pulse(to_pulse),
    .finish  (finish),
    .req_op  (req_op),
    .req_bank(req_bank),
    .req_port(req_port),
    .req_data(req_data),
    .op_q    (op_q),
    .bus_in  (bus_in),
    .bus_out (bus_out),
    .ctrl    (ctrl),
    .dir_in  (dir_in),
    .rd_data (rd_data),
    .done    (done)
  );

endmodule

// File: rtl/xbus_host_seq_chk.sv
module xbus_host_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [1:0]    req_op,
  input logic [DW-1:0] bus_out,
  input logic [3:0]    ctrl,
  input logic          dir_in,
  input logic          busy,
  input logic          done
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (ctrl == 4'd4 && !dir_in && !busy && !done));

  p_ctrl_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (ctrl == 4'd4 || ctrl == 4'd12 || ctrl == 4'd5));

  p_dir_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    dir_in |-> (ctrl == 4'd5 && busy));

  p_sel_bus_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl == 4'd12) |-> $stable(bus_out));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && ctrl == 4'd4 && !dir_in));

  p_busy_end_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_rsvd_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid && req_op == 2'd3) |=> !busy);

endmodule

bind xbus_host_seq xbus_host_seq_chk #(.DW(DW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_op   (req_op),
  .bus_out  (bus_out),
  .ctrl     (ctrl),
  .dir_in   (dir_in),
  .busy     (busy),
  .done     (done)
);

// File: tb/xbus_host_seq_tb_top.sv
module xbus_host_seq_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [2:0] req_bank = 3'd0;
  logic [3:0] req_port = 4'd0;
  logic [7:0] req_data = 8'd0;
  logic [7:0] hold_cfg = 8'd0;
  logic [7:0] bus_in = 8'd0;
  logic [7:0] bus_out;
  logic [3:0] ctrl;
  logic       dir_in;
  logic       busy;
  logic       done;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_bus = 8'd0;
  logic [7:0] exp_rd = 8'd0;

  always #4 clk = ~clk;

  xbus_host_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_bank(req_bank), .req_port(req_port), .req_data(req_data),
    .hold_cfg(hold_cfg), .bus_in(bus_in), .bus_out(bus_out), .ctrl(ctrl),
    .dir_in(dir_in), .busy(busy), .done(done), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Issues one request and traces every cycle until completion.
  task automatic run_op(input logic [1:0] op, input logic [2:0] bank,
                        input logic [3:0] port, input logic [7:0] data,
                        input int n, input logic [7:0] rd_early,
                        input logic [7:0] rd_final, input bit poke,
                        input logic [7:0] cfg_late);
    int setup_n;
    int total;
    logic [3:0] pcode;
    string tag;
    tag = (op == 2'd0) ? "R3" : (op == 2'd1) ? "R4" : "R5";
    setup_n = (op == 2'd2) ? 0 : n;
    total = setup_n + n;
    pcode = (op == 2'd0) ? 4'd12 : 4'd5;
    if (op == 2'd0) exp_bus = {1'b0, bank, port};
    if (op == 2'd1) exp_bus = data;
    req_op = op; req_bank = bank; req_port = port; req_data = data;
    bus_in = rd_early;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= total; k++) begin
      check("R8 busy", busy, 1);
      check(tag, ctrl, (k <= setup_n) ? 4 : pcode);
      check("R2 dir", dir_in, (op == 2'd2) ? 1 : 0);
      check(tag, bus_out, exp_bus);
      check("R9 no early done", done, 0);
      if (k == 1 && cfg_late != 8'd0) hold_cfg = cfg_late;
      if (poke && k == 2) begin
        req_valid = 1'b1; req_op = 2'd2;
      end
      if (poke && k == 3) req_valid = 1'b0;
      if (op == 2'd2) bus_in = (k == n) ? rd_final : rd_early;
      @(negedge clk);
    end
    if (op == 2'd2) exp_rd = rd_final;
    check("R9 done", done, 1);
    check("R9 busy low", busy, 0);
    check("R9 ctrl idle", ctrl, 4);
    check("R6 rd_data", rd_data, exp_rd);
    @(negedge clk);
    check("R9 done single", done, 0);
    check("R8 stays idle", busy, 0);
  endtask

  task automatic t_reset;
    check("R1 ctrl", ctrl, 4);
    check("R1 dir", dir_in, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 bus", bus_out, 0);
    check("R1 rd", rd_data, 0);
  endtask

  task automatic t_default_hold;   // R7 default, R3, R4, R5, R6
    hold_cfg = 8'd0;
    run_op(2'd0, 3'd5, 4'd9, 8'h00, 3, 8'h00, 8'h00, 1'b0, 8'd0);
    run_op(2'd1, 3'd0, 4'd0, 8'hA7, 3, 8'h00, 8'h00, 1'b0, 8'd0);
    run_op(2'd2, 3'd0, 4'd0, 8'h00, 3, 8'h11, 8'hC3, 1'b0, 8'd0);
  endtask

  task automatic t_override_hold;  // R7 override
    hold_cfg = 8'd1;
    run_op(2'd0, 3'd7, 4'd15, 8'h00, 1, 8'h00, 8'h00, 1'b0, 8'd0);
    run_op(2'd2, 3'd0, 4'd0, 8'h00, 1, 8'h00, 8'h5A, 1'b0, 8'd0);
    hold_cfg = 8'd5;
    run_op(2'd1, 3'd0, 4'd0, 8'h3C, 5, 8'h00, 8'h00, 1'b0, 8'd0);
    run_op(2'd2, 3'd0, 4'd0, 8'h00, 5, 8'hFF, 8'h81, 1'b0, 8'd0);
  endtask

  task automatic t_busy_ignore;    // R8 and R7 sampling at acceptance
    hold_cfg = 8'd4;
    run_op(2'd1, 3'd0, 4'd0, 8'h96, 4, 8'h00, 8'h00, 1'b1, 8'd7);
    hold_cfg = 8'd3;
    run_op(2'd0, 3'd0, 4'd1, 8'h00, 3, 8'h00, 8'h00, 1'b1, 8'd0);
  endtask

  task automatic t_reserved;       // R10
    req_op = 2'd3; req_data = 8'hEE; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R10 busy", busy, 0);
      check("R10 ctrl", ctrl, 4);
      check("R10 bus", bus_out, exp_bus);
      check("R10 done", done, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_default_hold();
    t_override_hold();
    t_busy_ignore();
    t_reserved();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule